// File: doc/BRIEF.md
# Element-Width Saturating Add/Subtract Unit

This unit adds or subtracts two 64-bit operands at a chosen element width, with optional clamping. Each operand is read at a compute width: the wider of the source and destination element widths. The exact result is then clamped or wrapped to the destination width. An unsigned clamp uses the range 0 to 2^w-1. A signed clamp uses the two's-complement minimum and maximum of w bits.

For each result the unit can also produce a 4-bit condition field. This field holds less-than, greater-than and equal flags for the final element value, plus an overflow bit that reports whether clamping took place. There is no global sticky overflow state: the only record of saturation is the overflow bit of each element's own condition field.

The datapath is combinational. A parameter decides whether a single output register follows it. With the default setting, results appear one clock after the inputs that produced them.

Top module: `esat_unit`

## Requirements
- R1: The width code selects the element width: 00 is 64 bits, 01 is 8, 10 is 16 and 11 is 32. The result holds the destination-width value, and every result bit above that width is 0.
- R2: With saturation enabled and `sat_signed`=0, an exact result below 0 becomes 0. An exact result above 2^w-1 becomes 2^w-1, where w is the destination width.
- R3: With saturation enabled and `sat_signed`=1, an exact result outside the signed w-bit range becomes -2^(w-1) or 2^(w-1)-1. The value is written in two's complement.
- R4: Both operands are read at the wider of the source and destination widths. They are sign-extended when `sat_signed`=1 and zero-extended otherwise. The sum or difference is formed there, before it is reduced to the destination width.
- R5: `op_sub`=0 forms a+b and `op_sub`=1 forms a-b.
- R6: When `rc_en`=0, the condition field is 0000 whatever the result.
- R7: When `rc_en`=1, condition bit 0 (overflow) is 1 exactly when clamping changed the result. With saturation disabled, the result wraps modulo 2^w and bit 0 stays 0.
- R8: When `rc_en`=1, exactly one of bit 3 (lt), bit 2 (gt) and bit 1 (eq) is set. They compare the final result with zero: as a signed w-bit value when `sat_signed`=1, and as an unsigned value otherwise, in which case lt is never set.
- R9: With `OUT_REG`=1, the outputs change one clock after the inputs. While `rst_n` is low, `res` and `cond` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sub | input | 1 | 0 add, 1 subtract |
| sat_en | input | 1 | Enable clamping |
| sat_signed | input | 1 | 1 signed range, 0 unsigned range |
| rc_en | input | 1 | Enable condition field |
| src_ew | input | 2 | Source element-width code |
| dst_ew | input | 2 | Destination element-width code |
| opa | input | 64 | Operand a |
| opb | input | 64 | Operand b |
| res | output | 64 | Element result, zero above destination width |
| cond | output | 4 | {lt, gt, eq, ov} |

## Verification
Clamping and the compare flags are decided in the same cycle from the same value. The overflow bit and the relational flags must therefore describe the clamped result, not the exact one. Vectors are chosen so that the exact result and the clamped result fall on opposite sides of zero or of a range edge, and the checks confirm that lt, gt and eq follow the clamped value. A second overlap occurs when the width reduction and the clamp act on one input. Narrow destinations are fed from wider sources, and the expected result depends on reading the operands at the wider width.

// File: rtl/esat_pkg.sv
package esat_pkg;
    localparam int DW = 64;
    localparam int XW = DW + 2;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic ov;
    } cond_t;

    function automatic logic [6:0] ew_bits(input logic [1:0] code);
        unique case (code)
            2'b01:   return 7'd8;
            2'b10:   return 7'd16;
            2'b11:   return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

    function automatic logic [1:0] ew_wider(input logic [1:0] x, input logic [1:0] y);
        return (ew_bits(x) >= ew_bits(y)) ? x : y;
    endfunction

    function automatic logic signed [XW-1:0] ew_extend(input logic [DW-1:0] v,
                                                        input logic [1:0] code,
                                                        input logic sgn);
        logic signed [XW-1:0] e;
        unique case (code)
            2'b01:   e = sgn ? {{(XW-8){v[7]}},   v[7:0]}  : {{(XW-8){1'b0}},  v[7:0]};
            2'b10:   e = sgn ? {{(XW-16){v[15]}}, v[15:0]} : {{(XW-16){1'b0}}, v[15:0]};
            2'b11:   e = sgn ? {{(XW-32){v[31]}}, v[31:0]} : {{(XW-32){1'b0}}, v[31:0]};
            default: e = sgn ? {{(XW-DW){v[DW-1]}}, v}     : {{(XW-DW){1'b0}}, v};
        endcase
        return e;
    endfunction
endpackage

// File: rtl/esat_limits.sv
module esat_limits
    import esat_pkg::*;
(
    input  logic [1:0]           dst_ew,
    output logic signed [XW-1:0] umax,
    output logic signed [XW-1:0] smax,
    output logic signed [XW-1:0] smin
);
    logic [6:0] w;
    logic signed [XW-1:0] one;

    always_comb begin
        w    = ew_bits(dst_ew);
        one  = {{(XW-1){1'b0}}, 1'b1};
        umax = (one <<< w) - one;
        smax = (one <<< (w - 7'd1)) - one;
        smin = -(one <<< (w - 7'd1));
    end
endmodule

// File: rtl/esat_core.sv
module esat_core
    import esat_pkg::*;
(
    input  logic          op_sub,
    input  logic          sat_en,
    input  logic          sat_signed,
    input  logic [1:0]    src_ew,
    input  logic [1:0]    dst_ew,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] val,
    output logic          clamped
);
    logic signed [XW-1:0] umax, smax, smin;
    logic signed [XW-1:0] ea, eb, exact, fixed;
    logic [1:0] cw;

    esat_limits u_lim (
        .dst_ew (dst_ew),
        .umax   (umax),
        .smax   (smax),
        .smin   (smin)
    );

    always_comb begin
        cw      = ew_wider(src_ew, dst_ew);
        ea      = ew_extend(opa, cw, sat_signed);
        eb      = ew_extend(opb, cw, sat_signed);
        exact   = op_sub ? (ea - eb) : (ea + eb);
        fixed   = exact;
        clamped = 1'b0;
        if (sat_en) begin
            if (sat_signed) begin
                if (exact > smax) begin
                    fixed = smax; clamped = 1'b1;
                end else if (exact < smin) begin
                    fixed = smin; clamped = 1'b1;
                end
            end else begin
                if (exact < 0) begin
                    fixed = '0; clamped = 1'b1;
                end else if (exact > umax) begin
                    fixed = umax; clamped = 1'b1;
                end
            end
        end
        val = fixed[DW-1:0] & umax[DW-1:0];
    end
endmodule

// File: rtl/esat_flags.sv
module esat_flags
    import esat_pkg::*;
(
    input  logic [DW-1:0] val,
    input  logic [1:0]    dst_ew,
    input  logic          sat_signed,
    input  logic          rc_en,
    input  logic          clamped,
    output cond_t         cf
);
    logic top_bit;

    always_comb begin
        unique case (dst_ew)
            2'b01:   top_bit = val[7];
            2'b10:   top_bit = val[15];
            2'b11:   top_bit = val[31];
            default: top_bit = val[DW-1];
        endcase
        cf = '0;
        if (rc_en) begin
            cf.eq = (val == '0);
            cf.lt = sat_signed && top_bit;
            cf.gt = !cf.eq && !cf.lt;
            cf.ov = clamped;
        end
    end
endmodule

// File: rtl/esat_unit.sv
module esat_unit
    import esat_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_sub,
    input  logic          sat_en,
    input  logic          sat_signed,
    input  logic          rc_en,
    input  logic [1:0]    src_ew,
    input  logic [1:0]    dst_ew,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] res,
    output logic [3:0]    cond
);
    logic [DW-1:0] val;
    logic          clamped;
    cond_t         cf;

    esat_core u_core (
        .op_sub     (op_sub),
        .sat_en     (sat_en),
        .sat_signed (sat_signed),
        .src_ew     (src_ew),
        .dst_ew     (dst_ew),
        .opa        (opa),
        .opb        (opb),
        .val        (val),
        .clamped    (clamped)
    );

    esat_flags u_flags (
        .val        (val),
        .dst_ew     (dst_ew),
        .sat_signed (sat_signed),
        .rc_en      (rc_en),
        .clamped    (clamped),
        .cf         (cf)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res  <= '0;
                    cond <= '0;
                end else begin
                    res  <= val;
                    cond <= cf;
                end
            end
        end else begin : g_comb
            assign res  = val;
            assign cond = cf;
        end
    endgenerate
endmodule

// File: rtl/esat_unit_chk.sv
module esat_unit_chk
    import esat_pkg::*;
#(
    parameter bit LAT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sat_en,
    input logic          sat_signed,
    input logic          rc_en,
    input logic [1:0]    dst_ew,
    input logic [DW-1:0] res,
    input logic [3:0]    cond
);
    logic       armed;
    logic       d_sat, d_sgn, d_rc;
    logic [1:0] d_dst;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    generate
        if (LAT) begin : g_dly
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    d_sat <= 1'b0; d_sgn <= 1'b0; d_rc <= 1'b0; d_dst <= 2'b00;
                end else begin
                    d_sat <= sat_en; d_sgn <= sat_signed; d_rc <= rc_en; d_dst <= dst_ew;
                end
            end
        end else begin : g_now
            assign d_sat = sat_en;
            assign d_sgn = sat_signed;
            assign d_rc  = rc_en;
            assign d_dst = dst_ew;
        end
    endgenerate

    function automatic logic [DW-1:0] top_mask(input logic [1:0] code);
        unique case (code)
            2'b01:   return 64'h0000_0000_0000_00FF;
            2'b10:   return 64'h0000_0000_0000_FFFF;
            2'b11:   return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (res & ~top_mask(d_dst)) == '0); // R1
    AST_UNSIGNED_CLAMP_EDGE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (d_rc && d_sat && !d_sgn && cond[0]) |-> (res == '0 || res == top_mask(d_dst))); // R2
    AST_RC_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !d_rc |-> (cond == 4'b0000)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !d_sat |-> !cond[0]); // R7
    AST_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        d_rc |-> ($countones(cond[3:1]) == 1)); // R8
    AST_UNSIGNED_NO_LT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !d_sgn |-> !cond[3]); // R8
    AST_RESET_ZERO: assert property (@(posedge clk)
        (LAT && $past(!rst_n) && armed == 1'b0 && !rst_n) |-> (res == '0 && cond == 4'b0000)); // R9
endmodule

bind esat_unit esat_unit_chk #(.LAT(OUT_REG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sat_en     (sat_en),
    .sat_signed (sat_signed),
    .rc_en      (rc_en),
    .dst_ew     (dst_ew),
    .res        (res),
    .cond       (cond)
);

// File: tb/test_esat_unit.sv
module test_esat_unit;
    typedef struct packed {
        logic        sub;
        logic        sat;
        logic        sgn;
        logic        rc;
        logic [1:0]  src;
        logic [1:0]  dst;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] res;
        logic [3:0]  cond;
    } vec_t;

    localparam int NV = 17;
    // cond bits: {lt, gt, eq, ov}
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,64'd5,64'd7,64'd12,4'b0100},                                   // R1 64-bit add
        '{1'b0,1'b0,1'b0,1'b1,2'b01,2'b01,64'hABCD_00F0,64'h20,64'h10,4'b0100},                           // R1 R7 8-bit wrap
        '{1'b0,1'b1,1'b0,1'b1,2'b01,2'b01,64'hF0,64'h20,64'hFF,4'b0101},                                  // R2 unsigned high
        '{1'b1,1'b1,1'b0,1'b1,2'b10,2'b10,64'd5,64'd9,64'd0,4'b0011},                                     // R2 R5 unsigned low
        '{1'b0,1'b1,1'b1,1'b1,2'b10,2'b10,64'h7FFF,64'h1,64'h7FFF,4'b0101},                               // R3 signed 16 max
        '{1'b1,1'b1,1'b1,1'b1,2'b11,2'b11,64'h8000_0000,64'h1,64'h8000_0000,4'b1001},                     // R3 signed 32 min
        '{1'b0,1'b1,1'b1,1'b1,2'b00,2'b00,64'h7FFF_FFFF_FFFF_FFFF,64'h1,64'h7FFF_FFFF_FFFF_FFFF,4'b0101}, // R3 signed 64 max
        '{1'b0,1'b1,1'b0,1'b1,2'b00,2'b00,64'hFFFF_FFFF_FFFF_FFFF,64'h2,64'hFFFF_FFFF_FFFF_FFFF,4'b0101}, // R2 unsigned 64 max
        '{1'b0,1'b1,1'b0,1'b1,2'b10,2'b01,64'h0100,64'h0001,64'hFF,4'b0101},                              // R4 wide src clamp
        '{1'b0,1'b0,1'b0,1'b1,2'b10,2'b01,64'h0100,64'h0001,64'h01,4'b0100},                              // R4 wide src wrap
        '{1'b0,1'b1,1'b0,1'b0,2'b01,2'b01,64'hF0,64'h20,64'hFF,4'b0000},                                  // R6 rc off
        '{1'b0,1'b0,1'b1,1'b1,2'b01,2'b01,64'h7F,64'h1,64'h80,4'b1000},                                   // R7 signed wrap
        '{1'b1,1'b0,1'b1,1'b1,2'b00,2'b00,64'd3,64'd5,64'hFFFF_FFFF_FFFF_FFFE,4'b1000},                   // R8 signed negative
        '{1'b1,1'b0,1'b0,1'b1,2'b11,2'b11,64'd3,64'd5,64'hFFFF_FFFE,4'b0100},                             // R8 unsigned no lt
        '{1'b1,1'b0,1'b0,1'b1,2'b00,2'b00,64'h1234,64'h1234,64'd0,4'b0010},                               // R5 R8 equal
        '{1'b1,1'b1,1'b1,1'b1,2'b11,2'b01,64'hF0,64'h0,64'h7F,4'b0101},                                   // R4 signed wide src
        '{1'b0,1'b1,1'b1,1'b1,2'b10,2'b01,64'hFF00,64'h0,64'h80,4'b1001}                                  // R3 R4 signed wide neg
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_sub = 1'b0, sat_en = 1'b0, sat_signed = 1'b0, rc_en = 1'b0;
    logic [1:0]  src_ew = 2'b00, dst_ew = 2'b00;
    logic [63:0] opa = '0, opb = '0;
    logic [63:0] res;
    logic [3:0]  cond;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    esat_unit i_esat_unit (
        .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .sat_en(sat_en),
        .sat_signed(sat_signed), .rc_en(rc_en), .src_ew(src_ew), .dst_ew(dst_ew),
        .opa(opa), .opb(opb), .res(res), .cond(cond)
    );

    task automatic check(input string tag, input logic [63:0] ar, input logic [3:0] ac,
                         input logic [63:0] er, input logic [3:0] ec);
        checks++;
        if (ar !== er || ac !== ec) begin
            errors++;
            $display("FAIL %s: res=%h cond=%b expected res=%h cond=%b", tag, ar, ac, er, ec);
        end
    endtask

    task automatic drive(input vec_t v);
        op_sub = v.sub; sat_en = v.sat; sat_signed = v.sgn; rc_en = v.rc;
        src_ew = v.src; dst_ew = v.dst; opa = v.a; opb = v.b;
    endtask

    initial begin
        // R9: outputs held at zero in reset even with live inputs
        drive(VECS[2]);
        repeat (3) @(negedge clk);
        check("R9 reset state", res, cond, 64'd0, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("vector %0d", i), res, cond, VECS[i].res, VECS[i].cond);
        end
        // R9: one-cycle latency, output holds the previous vector until the edge
        drive(VECS[0]);
        #1;
        check("R9 latency hold", res, cond, VECS[NV-1].res, VECS[NV-1].cond);
        @(negedge clk);
        check("R9 latency update", res, cond, VECS[0].res, VECS[0].cond);
        // R6: rc off on a signed clamp
        drive('{1'b1,1'b1,1'b1,1'b0,2'b11,2'b11,64'h8000_0000,64'h1,64'h8000_0000,4'b0000});
        @(negedge clk);
        check("R6 rc off signed clamp", res, cond, 64'h8000_0000, 4'b0000);
        // R1: 16-bit subtract wrap, upper bits of inputs discarded
        drive('{1'b1,1'b0,1'b0,1'b1,2'b10,2'b10,64'hFFFF_0000,64'h1,64'hFFFF,4'b0100});
        @(negedge clk);
        check("R1 R5 16-bit borrow wrap", res, cond, 64'hFFFF, 4'b0100);
        // R9: reset again clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears", res, cond, 64'd0, 4'b0000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (10000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: res=%h cond=%b expected completion", res, cond);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule